// File: doc/BRIEF.md
# Programmable Square-Wave Tone Bank

This block holds the tone section of a small programmable sound generator. It has three independent square-wave channels. Each channel counts prescaled step ticks up to a 12-bit period. When the count reaches that period the channel clears its counter and flips its square output, so the output has a 50% duty cycle. A shared step generator makes the ticks. An external rate-select input halves the step rate.

A mixer combines each channel's square with a noise bit that is shared by all channels. Per-channel mask bits decide which of the two terms take part. When the combined bit is high, the channel drives a 4-bit amplitude code. That code is either the channel's fixed level or an envelope level supplied from outside, as a bit in the channel's level register selects. When the combined bit is low, the code is 0.

Software reaches the registers through a two-step bus. An address-strobe cycle latches a register number. A write-strobe cycle then stores a byte into the latched register. The latched register can always be read back on a read-data port.

Top module: `psg_tone_bank`

## Requirements
- R1: After reset every amplitude code is 0, every register reads back 0, every channel counter is 0 and every square output is low.
- R2: A channel's period is {coarse[3:0], fine[7:0]}. Its square output flips after exactly that many step ticks, then its counter restarts from 0.
- R3: A period value of 0 behaves as a period of 1, so the square flips on every step tick.
- R4: When level bit 4 is 0 and the gated bit is 1, the channel's amplitude code equals level bits [3:0].
- R5: When level bit 4 is 1 and the gated bit is 1, the amplitude code equals the env_level input.
- R6: Mask register bit n (n = 0..2) masks channel n's tone and bit 3+n masks its noise. The gated bit is (square | tone mask) & (noise_bit | noise mask). The amplitude code is 0 whenever the gated bit is 0.
- R7: With clk_sel low a step tick occurs once every STEP_DIV clocks (default 2). With clk_sel high it occurs once every 2*STEP_DIV clocks.
- R8: An address strobe latches bus_data[3:0] as the register number. A write strobe stores bus_data into the register latched before that edge. When both strobes are high in one cycle, the write goes to the old register and the new number is latched.
- R9: The register map is: fine of channel n at 2n, coarse of channel n at 2n+1, mask at 7, level of channel n at 8+n. rd_data shows the latched register with its unused high bits (coarse [7:4], level [7:5], mask [7:6]) as 0. Writes to addresses 6 and 11 to 15 are ignored, and those addresses read 0.
- R10: A period write takes effect from the next tick. If the counter already stands at or past the new period, the next tick wraps the counter and flips the square.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 1 | High halves the step tick rate |
| addr_stb | input | 1 | Latch bus_data[3:0] as the register number |
| wr_stb | input | 1 | Write bus_data into the latched register |
| bus_data | input | 8 | Bus byte for address or data |
| noise_bit | input | 1 | Shared noise bit |
| env_level | input | 4 | Envelope amplitude, used when level bit 4 is set |
| amp_codes | output | 12 | Amplitude code of channel n at [4n+3:4n] |
| rd_data | output | 8 | Contents of the latched register |

## Verification
Two pairs of events can fall in the same cycle, and the bench provokes both.

The first pair is a period rewrite and the channel's wrap. The bench keeps writing shorter periods while the counters run at arbitrary phases. Some of these writes land on the very tick that wraps the counter, and others land when the counter already exceeds the new period. The behavioural model settles each tick against the period that was held before the edge, and it is compared on every clock.

The second pair is an address strobe and a write strobe in the same cycle. The bench raises both at once. It then checks that the byte landed in the previously latched register and that the new number was latched, by reading back both registers.

// File: rtl/psg_tone_pkg.sv
package psg_tone_pkg;
  localparam int BUS_W     = 8;
  localparam int ADDR_W    = 4;
  localparam int COARSE_W  = 4;
  localparam int PER_W     = BUS_W + COARSE_W;
  localparam int LVL_W     = 5;
  localparam int AMP_W     = 4;
  localparam int ADDR_MASK = 7;
  localparam int ADDR_LVL0 = 8;

  function automatic logic [ADDR_W-1:0] fine_addr(input int ch);
    return ADDR_W'(2 * ch);
  endfunction

  function automatic logic [ADDR_W-1:0] coarse_addr(input int ch);
    return ADDR_W'(2 * ch + 1);
  endfunction

  function automatic logic [ADDR_W-1:0] lvl_addr(input int ch);
    return ADDR_W'(ADDR_LVL0 + ch);
  endfunction
endpackage

// File: rtl/psg_step_gen.sv
module psg_step_gen #(
  parameter int STEP_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic half_rate,
  output logic tick
);
  localparam int CW = $clog2(2 * STEP_DIV + 1);

  logic [CW-1:0] cnt_q, cnt_d, limit_m1;

  always_comb begin
    limit_m1 = half_rate ? CW'(2 * STEP_DIV - 1) : CW'(STEP_DIV - 1);
    tick     = (cnt_q >= limit_m1);
    cnt_d    = tick ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_SLOW_NO_BACK2BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && half_rate) |=> (!tick || !half_rate)); // R7
endmodule

// File: rtl/psg_tone_regs.sv
module psg_tone_regs
  import psg_tone_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           addr_stb,
  input  logic                           wr_stb,
  input  logic [BUS_W-1:0]               bus_data,
  output logic [NCH-1:0][BUS_W-1:0]      fine_o,
  output logic [NCH-1:0][COARSE_W-1:0]   coarse_o,
  output logic [NCH-1:0][LVL_W-1:0]      lvl_o,
  output logic [2*NCH-1:0]               mask_o,
  output logic [BUS_W-1:0]               rd_data
);
  logic [ADDR_W-1:0]                addr_q, addr_d;
  logic [NCH-1:0][BUS_W-1:0]        fine_q, fine_d;
  logic [NCH-1:0][COARSE_W-1:0]     coarse_q, coarse_d;
  logic [NCH-1:0][LVL_W-1:0]        lvl_q, lvl_d;
  logic [2*NCH-1:0]                 mask_q, mask_d;

  always_comb begin
    addr_d   = addr_stb ? bus_data[ADDR_W-1:0] : addr_q;
    fine_d   = fine_q;
    coarse_d = coarse_q;
    lvl_d    = lvl_q;
    mask_d   = mask_q;
    if (wr_stb) begin
      for (int c = 0; c < NCH; c++) begin
        if (addr_q == fine_addr(c))   fine_d[c]   = bus_data;
        if (addr_q == coarse_addr(c)) coarse_d[c] = bus_data[COARSE_W-1:0];
        if (addr_q == lvl_addr(c))    lvl_d[c]    = bus_data[LVL_W-1:0];
      end
      if (addr_q == ADDR_W'(ADDR_MASK)) mask_d = bus_data[2*NCH-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      fine_q   <= '0;
      coarse_q <= '0;
      lvl_q    <= '0;
      mask_q   <= '0;
    end else begin
      addr_q   <= addr_d;
      fine_q   <= fine_d;
      coarse_q <= coarse_d;
      lvl_q    <= lvl_d;
      mask_q   <= mask_d;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NCH; c++) begin
      if (addr_q == fine_addr(c))   rd_data = fine_q[c];
      if (addr_q == coarse_addr(c)) rd_data = {{(BUS_W-COARSE_W){1'b0}}, coarse_q[c]};
      if (addr_q == lvl_addr(c))    rd_data = {{(BUS_W-LVL_W){1'b0}}, lvl_q[c]};
    end
    if (addr_q == ADDR_W'(ADDR_MASK)) rd_data = {{(BUS_W-2*NCH){1'b0}}, mask_q};
  end

  assign fine_o   = fine_q;
  assign coarse_o = coarse_q;
  assign lvl_o    = lvl_q;
  assign mask_o   = mask_q;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_stb |=> $stable(addr_q)); // R8
  AST_FINE0_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !addr_stb && addr_q == '0) |=> (rd_data == $past(bus_data))); // R8
endmodule

// File: rtl/psg_tone_chan.sv
module psg_tone_chan
  import psg_tone_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [PER_W-1:0] period_raw,
  input  logic             tone_mask,
  input  logic             noise_mask,
  input  logic             noise_bit,
  input  logic [LVL_W-1:0] level,
  input  logic [AMP_W-1:0] env_level,
  output logic [AMP_W-1:0] amp
);
  logic [PER_W-1:0] cnt_q, cnt_d, period_eff;
  logic             tone_q, tone_d, wrap, gate;

  always_comb begin
    period_eff = (period_raw == '0) ? PER_W'(1) : period_raw;
    wrap       = ({1'b0, cnt_q} + (PER_W+1)'(1)) >= {1'b0, period_eff};
    cnt_d      = cnt_q;
    tone_d     = tone_q;
    if (tick) begin
      if (wrap) begin
        cnt_d  = '0;
        tone_d = ~tone_q;
      end else begin
        cnt_d  = cnt_q + PER_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tone_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tone_q <= tone_d;
    end
  end

  always_comb begin
    gate = (tone_q | tone_mask) & (noise_bit | noise_mask);
    if (!gate)         amp = '0;
    else if (level[4]) amp = env_level;
    else               amp = level[AMP_W-1:0];
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(cnt_q) && $stable(tone_q))); // R2
  AST_WRAP_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && wrap) |=> (cnt_q == '0 && tone_q != $past(tone_q))); // R10
  AST_GATE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!tone_q && !tone_mask) |-> (amp == '0)); // R6
  AST_ENV_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (level[4] && amp != '0) |-> (amp == env_level)); // R5
endmodule

// File: rtl/psg_tone_bank.sv
module psg_tone_bank
  import psg_tone_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int STEP_DIV = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_sel,
  input  logic                    addr_stb,
  input  logic                    wr_stb,
  input  logic [7:0]              bus_data,
  input  logic                    noise_bit,
  input  logic [3:0]              env_level,
  output logic [NUM_CH*4-1:0]     amp_codes,
  output logic [7:0]              rd_data
);
  logic                            tick;
  logic [NUM_CH-1:0][BUS_W-1:0]    fine;
  logic [NUM_CH-1:0][COARSE_W-1:0] coarse;
  logic [NUM_CH-1:0][LVL_W-1:0]    lvl;
  logic [2*NUM_CH-1:0]             mask;

  psg_step_gen #(.STEP_DIV(STEP_DIV)) step_i (
    .clk(clk), .rst_n(rst_n), .half_rate(clk_sel), .tick(tick)
  );

  psg_tone_regs #(.NCH(NUM_CH)) regs_i (
    .clk(clk), .rst_n(rst_n), .addr_stb(addr_stb), .wr_stb(wr_stb),
    .bus_data(bus_data), .fine_o(fine), .coarse_o(coarse), .lvl_o(lvl),
    .mask_o(mask), .rd_data(rd_data)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    psg_tone_chan chan_i (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .period_raw({coarse[c], fine[c]}),
      .tone_mask(mask[c]), .noise_mask(mask[NUM_CH+c]),
      .noise_bit(noise_bit), .level(lvl[c]), .env_level(env_level),
      .amp(amp_codes[4*c +: 4])
    );
  end
endmodule

// File: tb/psg_tone_bank_tb.sv
module psg_tone_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int DIV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_sel = 1'b0, addr_stb = 1'b0, wr_stb = 1'b0, noise_bit = 1'b0;
  logic [7:0] bus_data = '0;
  logic [3:0] env_level = '0;
  logic [NCH*4-1:0] amp_codes;
  logic [7:0] rd_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  psg_tone_bank dut_i (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .addr_stb(addr_stb),
    .wr_stb(wr_stb), .bus_data(bus_data), .noise_bit(noise_bit),
    .env_level(env_level), .amp_codes(amp_codes), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_fine[NCH], m_coarse[NCH], m_lvl[NCH], m_cnt[NCH], m_tone[NCH];
  int m_mask, m_addr, m_pc;

  function automatic int exp_rd(int a);
    if (a < 2*NCH)          return (a % 2 == 0) ? m_fine[a/2] : m_coarse[a/2];
    if (a == 7)             return m_mask;
    if (a >= 8 && a < 8+NCH) return m_lvl[a-8];
    return 0;
  endfunction

  function automatic int exp_amp(int c);
    int g;
    g = (m_tone[c] | ((m_mask >> c) & 1)) & (int'(noise_bit) | ((m_mask >> (3+c)) & 1));
    if (g == 0) return 0;
    if (m_lvl[c] >= 16) return int'(env_level);
    return m_lvl[c] % 16;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_fine[c] = 0; m_coarse[c] = 0; m_lvl[c] = 0; m_cnt[c] = 0; m_tone[c] = 0;
      end
      m_mask = 0; m_addr = 0; m_pc = 0;
    end else begin
      int lim, per, a;
      bit tk;
      lim = clk_sel ? 2*DIV : DIV;
      tk = (m_pc + 1 >= lim);
      m_pc = tk ? 0 : m_pc + 1;
      for (int c = 0; c < NCH; c++) begin
        per = m_coarse[c] * 256 + m_fine[c];
        if (per == 0) per = 1;
        if (tk) begin
          if (m_cnt[c] + 1 >= per) begin m_cnt[c] = 0; m_tone[c] ^= 1; end
          else m_cnt[c]++;
        end
      end
      a = m_addr;
      if (wr_stb) begin
        if (a < 2*NCH) begin
          if (a % 2 == 0) m_fine[a/2] = int'(bus_data);
          else m_coarse[a/2] = int'(bus_data) % 16;
        end else if (a == 7) m_mask = int'(bus_data) % 64;
        else if (a >= 8 && a < 8+NCH) m_lvl[a-8] = int'(bus_data) % 32;
      end
      if (addr_stb) m_addr = int'(bus_data) % 16;
    end
  end

  task automatic check(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  // compare on every clock
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      for (int c = 0; c < NCH; c++)
        check(int'(amp_codes[4*c +: 4]) == exp_amp(c), "R2 R3 R4 R5 R6 R7 R10 amp",
              int'(amp_codes[4*c +: 4]), exp_amp(c));
      check(int'(rd_data) == exp_rd(m_addr), "R8 R9 rd_data", int'(rd_data), exp_rd(m_addr));
    end
  end

  task automatic latch(int a);
    @(negedge clk); addr_stb = 1; bus_data = 8'(a);
    @(negedge clk); addr_stb = 0;
  endtask

  task automatic wr_reg(int a, int d);
    latch(a);
    wr_stb = 1; bus_data = 8'(d);
    @(negedge clk); wr_stb = 0;
  endtask

  task automatic read_chk(int a, int expv, string tag);
    latch(a);
    #2; check(int'(rd_data) == expv, tag, int'(rd_data), expv);
  endtask

  task automatic run_rand(int n, bit vary_sel);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      noise_bit = 1'($urandom);
      env_level = 4'($urandom);
      if (vary_sel && ($urandom % 16 == 0)) clk_sel = ~clk_sel;
    end
  endtask

  task automatic count_toggles(int exp_n, string tag);
    int n = 0;
    logic [3:0] prev;
    @(negedge clk); #2; prev = amp_codes[7:4];
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #2;
      if (amp_codes[7:4] != prev) n++;
      prev = amp_codes[7:4];
    end
    check(n == exp_n, tag, n, exp_n);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    check(amp_codes == '0, "R1 amp after reset", int'(amp_codes), 0);
    for (int a = 0; a < 16; a++) read_chk(a, 0, "R1 register after reset");

    // readback masking and ignored addresses
    wr_reg(1, 8'hFF); #2; check(rd_data == 8'h0F, "R9 coarse high bits", rd_data, 8'h0F);
    wr_reg(6, 8'h55); #2; check(rd_data == 8'h00, "R9 unmapped 6", rd_data, 0);
    wr_reg(13, 8'hAA); #2; check(rd_data == 8'h00, "R9 unmapped 13", rd_data, 0);
    wr_reg(8, 8'hFF); #2; check(rd_data == 8'h1F, "R9 level high bits", rd_data, 8'h1F);
    wr_reg(7, 8'hFF); #2; check(rd_data == 8'h3F, "R9 mask high bits", rd_data, 8'h3F);

    // channel setup, noise masked
    wr_reg(7, 8'h38);
    wr_reg(0, 3);  wr_reg(1, 0);  wr_reg(8, 8'h0A);
    wr_reg(2, 0);  wr_reg(3, 0);  wr_reg(9, 8'h05);
    wr_reg(4, 5);  wr_reg(5, 1);  wr_reg(10, 8'h1F);
    run_rand(300, 0);

    // period 0 on channel 1 flips every tick
    count_toggles(20, "R3 zero period toggles every tick");
    clk_sel = 1; repeat (8) @(negedge clk);
    count_toggles(10, "R7 half rate ticks");
    clk_sel = 0; repeat (8) @(negedge clk);

    // both strobes in one cycle
    latch(0);
    addr_stb = 1; wr_stb = 1; bus_data = 8'h09;
    @(negedge clk); addr_stb = 0; wr_stb = 0; #2;
    check(rd_data == 8'h05, "R8 new address latched", rd_data, 8'h05);
    read_chk(0, 8'h09, "R8 write used old address");

    // gating variants
    wr_reg(7, 8'h00); run_rand(300, 0);
    wr_reg(7, 8'h07); run_rand(300, 0);
    wr_reg(7, 8'h38);

    // period rewrites while counting
    for (int k = 0; k < 12; k++) begin
      run_rand(int'($urandom % 40) + 5, 0);
      wr_reg(4, int'($urandom % 4));
      wr_reg(5, 0);
      wr_reg(0, int'($urandom % 6));
    end
    run_rand(200, 0);
    wr_reg(8, 8'h13); wr_reg(7, 8'h12);
    run_rand(600, 1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule